// File: doc/BRIEF.md
# Tone-Pair Guard-Time Qualifier and Receive Latch

This block sits behind a dual-tone frequency detector and decides when a detected tone pair counts as a digit. The detector supplies a raw "tone present" flag and an identifier for each of the two frequency groups. The block accepts a pair only after the flag has held for a programmable accept guard. It ends a digit only after the flag has been absent for a separate, programmable release guard, so brief dropouts inside a tone are ignored.

On acceptance the block raises an early steering output. After a programmable settling delay it raises a delayed steering flag. On that flag's rising edge it loads the 4-bit code of the pair into a receive register. Software reads the code through a read strobe. It can watch the delayed flag in a status word, or it can enable an active-low interrupt that reading the receive register clears.

All guard and settling values are clock-cycle counts taken from configuration inputs. The group identifiers are either 2-bit indices or 4-bit one-hot vectors, chosen by a parameter.

Top module: `tone_steer_latch`

## Requirements
- R1: While `rst` is high at a clock edge, the steering outputs, the status word and the receive register are cleared and `irq_n` is high. `rx_bus` then reads 0 even when `rd_rx` is high.
- R2: With accept guard A, `steer_early` rises at the edge that samples the (A+1)th consecutive high `tone_raw`. A burst of A or fewer high samples never raises it and latches nothing.
- R3: With release guard R, `steer_early` falls at the edge that samples the (R+1)th consecutive low `tone_raw`. A dropout of R or fewer low samples leaves it high.
- R4: The accept and release guards are set independently. A value of 0 makes acceptance or release happen at the first sample.
- R5: With settling value S, `steer_dly` rises S+1 edges after `steer_early` rises, provided `steer_early` is still high. It falls one edge after `steer_early` falls.
- R6: The receive register loads only at the edge where `steer_dly` rises. Group indices that change after acceptance do not alter it.
- R7: The code depends on the low-group index L (0..3 = 697, 770, 852, 941 Hz) and the high-group index H (0..3 = 1209, 1336, 1477, 1633 Hz). For H=3, the code is 0 when L=3 and 13+L otherwise. For L=3 with H<3, the code is 11, 10 and 12 for H = 0, 1 and 2. Otherwise the code is 3L+H+1.
- R8: `rx_bus` carries the receive register while `rd_rx` is high and 0 otherwise.
- R9: `status_bits[0]` equals `steer_dly`. `status_bits[1]` is the pending-interrupt flag.
- R10: The pending flag is set when `steer_dly` rises and cleared by an `rd_rx` edge. It is not set again until the next rise. `irq_n` is low exactly while `irq_en`, the pending flag and `steer_dly` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_raw | input | 1 | Raw tone-present flag from the detector |
| grp_lo | input | GRP_W (2) | Low-group frequency identifier |
| grp_hi | input | GRP_W (2) | High-group frequency identifier |
| accept_len | input | CNT_W (8) | Accept guard in cycles |
| release_len | input | CNT_W (8) | Release guard in cycles |
| settle_len | input | SET_W (4) | Settling delay in cycles |
| irq_en | input | 1 | Interrupt mode enable |
| rd_rx | input | 1 | Receive register read strobe |
| steer_early | output | 1 | Early steering output |
| steer_dly | output | 1 | Delayed steering flag |
| status_bits | output | 2 | {pending interrupt, delayed steering} |
| irq_n | output | 1 | Active-low interrupt |
| rx_bus | output | 4 | Receive data during a read, else 0 |

## Verification
Inputs change at falling edges, and each result is sampled at a falling edge after a counted number of rising edges. Counting from the falling edge that raises `tone_raw`, `steer_early` is due after A+1 edges and `steer_dly` after A+S+2 edges. Counting from the falling edge that drops the tone, `steer_early` falls after R+1 edges and `steer_dly` after R+2. The checks sample one edge before and one edge on each expected transition. `rx_bus` is combinational on `rd_rx`, so it is sampled shortly after the strobe is set. The interrupt clear shows one edge after the strobe. A scoreboard sweeps all sixteen pairs with short bursts mixed in. It matches each delayed-flag rise against the queued code, and it expects nothing to be queued for the short bursts.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
   typedef logic [3:0] code_t;

   // Pair code from low index lo and high index hi (R7).
   function automatic code_t pair_code(input logic [1:0] lo, input logic [1:0] hi);
      code_t c;
      if (hi == 2'd3) begin
         c = (lo == 2'd3) ? 4'd0 : code_t'(4'd13 + {2'b00, lo});
      end else if (lo == 2'd3) begin
         case (hi)
            2'd0:    c = 4'd11;
            2'd1:    c = 4'd10;
            default: c = 4'd12;
         endcase
      end else begin
         c = code_t'(({2'b00, lo} * 4'd3) + {2'b00, hi} + 4'd1);
      end
      return c;
   endfunction
endpackage

// File: rtl/tsl_grp_index.sv
module tsl_grp_index #(
   parameter int ONEHOT = 0,
   localparam int GRP_W = (ONEHOT != 0) ? 4 : 2
) (
   input  logic [GRP_W-1:0] grp_in,
   output logic [1:0]       idx
);
   if (ONEHOT != 0) begin : g_onehot
      always_comb begin
         idx = 2'd0;
         for (int i = 3; i >= 0; i--) begin
            if (grp_in[i]) idx = 2'(i);
         end
      end
   end else begin : g_indexed
      assign idx = grp_in[1:0];
   end
endmodule

// File: rtl/tsl_guard.sv
module tsl_guard #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tone_raw,
   input  logic [CNT_W-1:0] accept_len,
   input  logic [CNT_W-1:0] release_len,
   output logic             steer,
   output logic             accept_p
);
   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] limit;

   assign limit    = steer ? release_len : accept_len;
   assign accept_p = !steer && tone_raw && (run_cnt >= accept_len);

   always_ff @(posedge clk) begin
      if (rst) begin
         steer   <= 1'b0;
         run_cnt <= '0;
      end else if (tone_raw != steer) begin
         if (run_cnt >= limit) begin
            steer   <= tone_raw;
            run_cnt <= '0;
         end else begin
            run_cnt <= run_cnt + 1'b1;
         end
      end else begin
         run_cnt <= '0;
      end
   end

   assert_rise_needs_tone_R2: assert property (@(posedge clk) disable iff (rst)
      ($rose(steer) && !$past(rst)) |-> $past(tone_raw));
   assert_fall_needs_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      ($fell(steer) && !$past(rst)) |-> !$past(tone_raw));
endmodule

// File: rtl/tsl_settle.sv
module tsl_settle #(
   parameter int SET_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             steer,
   input  logic [SET_W-1:0] settle_len,
   output logic             dly,
   output logic             rise_p
);
   logic [SET_W-1:0] wait_cnt;

   assign rise_p = steer && !dly && (wait_cnt >= settle_len);

   always_ff @(posedge clk) begin
      if (rst || !steer) begin
         dly      <= 1'b0;
         wait_cnt <= '0;
      end else if (!dly) begin
         if (wait_cnt >= settle_len) begin
            dly      <= 1'b1;
            wait_cnt <= '0;
         end else begin
            wait_cnt <= wait_cnt + 1'b1;
         end
      end
   end

   assert_dly_follows_steer_R5: assert property (@(posedge clk) disable iff (rst)
      ($rose(dly) && !$past(rst)) |-> $past(steer));
   assert_dly_drops_after_steer_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(steer) && !$past(rst)) |-> !dly);
endmodule

// File: rtl/tone_steer_latch.sv
module tone_steer_latch #(
   parameter int CNT_W  = 8,
   parameter int SET_W  = 4,
   parameter int ONEHOT = 0,
   localparam int GRP_W = (ONEHOT != 0) ? 4 : 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tone_raw,
   input  logic [GRP_W-1:0] grp_lo,
   input  logic [GRP_W-1:0] grp_hi,
   input  logic [CNT_W-1:0] accept_len,
   input  logic [CNT_W-1:0] release_len,
   input  logic [SET_W-1:0] settle_len,
   input  logic             irq_en,
   input  logic             rd_rx,
   output logic             steer_early,
   output logic             steer_dly,
   output logic [1:0]       status_bits,
   output logic             irq_n,
   output logic [3:0]       rx_bus
);
   import tsl_pkg::*;

   if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
      $error("CNT_W out of range");
   end
   if (SET_W < 1 || SET_W > 16) begin : g_bad_set
      $error("SET_W out of range");
   end

   logic [1:0] lo_idx, hi_idx;
   logic       accept_p, rise_p;
   code_t      pend_code, rx_latch;
   logic       irq_pend;

   tsl_grp_index #(.ONEHOT(ONEHOT)) u_lo (.grp_in(grp_lo), .idx(lo_idx));
   tsl_grp_index #(.ONEHOT(ONEHOT)) u_hi (.grp_in(grp_hi), .idx(hi_idx));

   tsl_guard #(.CNT_W(CNT_W)) u_guard (
      .clk(clk), .rst(rst), .tone_raw(tone_raw),
      .accept_len(accept_len), .release_len(release_len),
      .steer(steer_early), .accept_p(accept_p));

   tsl_settle #(.SET_W(SET_W)) u_settle (
      .clk(clk), .rst(rst), .steer(steer_early),
      .settle_len(settle_len), .dly(steer_dly), .rise_p(rise_p));

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_code <= '0;
         rx_latch  <= '0;
         irq_pend  <= 1'b0;
      end else begin
         if (accept_p) pend_code <= pair_code(lo_idx, hi_idx);
         if (rise_p)   rx_latch  <= pend_code;
         if (rise_p)        irq_pend <= 1'b1;
         else if (rd_rx)    irq_pend <= 1'b0;
      end
   end

   assign status_bits = {irq_pend, steer_dly};
   assign irq_n       = !(irq_en && irq_pend && steer_dly);
   assign rx_bus      = rd_rx ? rx_latch : 4'd0;

   assert_latch_only_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
      (!$rose(steer_dly) && !$past(rst)) |-> $stable(rx_latch));
   assert_read_clears_irq_R10: assert property (@(posedge clk) disable iff (rst)
      ($past(rd_rx) && !$rose(steer_dly) && !$past(rst)) |-> irq_n);
   assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
      !irq_en |-> irq_n);
endmodule

// File: tb/tone_steer_latch_test.sv
module tone_steer_latch_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tone_raw = 1'b0;
   logic [1:0] grp_lo = '0, grp_hi = '0;
   logic [7:0] accept_len = '0, release_len = '0;
   logic [3:0] settle_len = '0;
   logic       irq_en = 1'b0, rd_rx = 1'b0;
   logic       steer_early, steer_dly, irq_n;
   logic [1:0] status_bits;
   logic [3:0] rx_bus;

   int  n_chk = 0, n_fail = 0;
   bit  mon_auto = 1'b0;
   bit  done = 1'b0;
   logic [3:0] exp_q[$];

   localparam logic [3:0] TBL [16] = '{
      4'd1, 4'd2, 4'd3, 4'd13,
      4'd4, 4'd5, 4'd6, 4'd14,
      4'd7, 4'd8, 4'd9, 4'd15,
      4'd11, 4'd10, 4'd12, 4'd0};

   always #5 clk = ~clk;

   tone_steer_latch uut (
      .clk(clk), .rst(rst), .tone_raw(tone_raw), .grp_lo(grp_lo), .grp_hi(grp_hi),
      .accept_len(accept_len), .release_len(release_len), .settle_len(settle_len),
      .irq_en(irq_en), .rd_rx(rd_rx), .steer_early(steer_early), .steer_dly(steer_dly),
      .status_bits(status_bits), .irq_n(irq_n), .rx_bus(rx_bus));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Driver: one tone of len high samples, then a quiet gap.
   task automatic send(input logic [1:0] l, input logic [1:0] h, input int len);
      @(negedge clk);
      grp_lo = l; grp_hi = h; tone_raw = 1'b1;
      if (len >= int'(accept_len) + 1) exp_q.push_back(TBL[{l, h}]);
      tick(len);
      tone_raw = 1'b0;
      tick(6);
   endtask

   // Monitor: reads the receive register on each delayed-flag rise.
   initial begin
      bit prev = 1'b0;
      forever begin
         @(negedge clk);
         if (mon_auto) begin
            if (status_bits[0] && !prev) begin
               rd_rx = 1'b1;
               #1;
               if (exp_q.size() == 0) chk(1'b0, "R6 unexpected latch", int'(rx_bus), -1);
               else begin
                  logic [3:0] e;
                  e = exp_q.pop_front();
                  chk(rx_bus == e, "R7 code", int'(rx_bus), int'(e));
               end
            end else rd_rx = 1'b0;
         end
         prev = status_bits[0];
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         summary();
      end
   end

   initial begin
      tick(3);
      // R1 reset state
      rd_rx = 1'b1; #1;
      chk(steer_early == 0 && steer_dly == 0, "R1 steering", int'(steer_early), 0);
      chk(status_bits == 0 && irq_n == 1, "R1 status/irq", int'(status_bits), 0);
      chk(rx_bus == 0, "R1 latch", int'(rx_bus), 0);
      rd_rx = 1'b0;
      rst = 1'b0;
      accept_len = 8'd3; release_len = 8'd2; settle_len = 4'd2; irq_en = 1'b1;
      tick(1);

      // R2 short burst of A high samples
      tone_raw = 1'b1; grp_lo = 2'd1; grp_hi = 2'd2;
      tick(3); tone_raw = 1'b0;
      chk(steer_early == 0, "R2 short burst", int'(steer_early), 0);
      tick(8);
      chk(status_bits[0] == 0, "R2 no delayed flag", int'(status_bits[0]), 0);
      rd_rx = 1'b1; #1;
      chk(rx_bus == 0, "R6 nothing latched", int'(rx_bus), 0);
      rd_rx = 1'b0;

      // Full tone 852/1336 -> 8
      tick(1);
      tone_raw = 1'b1; grp_lo = 2'd2; grp_hi = 2'd1;
      tick(3);
      chk(steer_early == 0, "R2 before accept", int'(steer_early), 0);
      tick(1);
      chk(steer_early == 1, "R2 accept edge", int'(steer_early), 1);
      tick(2);
      chk(steer_dly == 0, "R5 before settle", int'(steer_dly), 0);
      tick(1);
      chk(steer_dly == 1, "R5 settle edge", int'(steer_dly), 1);
      chk(irq_n == 0, "R10 irq low", int'(irq_n), 0);
      chk(status_bits == 2'b11, "R9 status", int'(status_bits), 3);
      chk(rx_bus == 0, "R8 bus idle", int'(rx_bus), 0);
      grp_lo = 2'd0; grp_hi = 2'd0;
      rd_rx = 1'b1; #1;
      chk(rx_bus == 4'd8, "R8 R7 read 852/1336", int'(rx_bus), 8);
      tick(1); rd_rx = 1'b0; #1;
      chk(irq_n == 1, "R10 read clears", int'(irq_n), 1);
      chk(status_bits == 2'b01, "R9 status after read", int'(status_bits), 1);
      // R3 dropout of R low samples
      tone_raw = 1'b0; tick(2); tone_raw = 1'b1;
      chk(steer_early == 1, "R3 dropout ridden", int'(steer_early), 1);
      tick(3);
      tone_raw = 1'b0;
      tick(2);
      chk(steer_early == 1, "R3 before release", int'(steer_early), 1);
      tick(1);
      chk(steer_early == 0 && steer_dly == 1, "R3 release edge", int'(steer_early), 0);
      tick(1);
      chk(steer_dly == 0, "R5 delayed fall", int'(steer_dly), 0);
      chk(irq_n == 1, "R10 not rearmed", int'(irq_n), 1);
      rd_rx = 1'b1; #1;
      chk(rx_bus == 4'd8, "R6 latch kept", int'(rx_bus), 8);
      tick(1); rd_rx = 1'b0;

      // R4 zero guards, irq disabled
      accept_len = 8'd0; release_len = 8'd0; settle_len = 4'd0; irq_en = 1'b0;
      tick(1);
      tone_raw = 1'b1; grp_lo = 2'd3; grp_hi = 2'd0;
      tick(1);
      chk(steer_early == 1, "R4 zero accept", int'(steer_early), 1);
      tick(1);
      chk(steer_dly == 1 && irq_n == 1, "R10 irq disabled", int'(irq_n), 1);
      tone_raw = 1'b0;
      tick(1);
      chk(steer_early == 0, "R4 zero release", int'(steer_early), 0);
      tick(1);
      rd_rx = 1'b1; #1;
      chk(rx_bus == 4'd11, "R7 941/1209", int'(rx_bus), 11);
      tick(1); rd_rx = 1'b0;

      // Scoreboard sweep of all pairs
      accept_len = 8'd2; release_len = 8'd1; settle_len = 4'd1; irq_en = 1'b1;
      mon_auto = 1'b1;
      for (int i = 0; i < 16; i++) begin
         send(2'(i >> 2), 2'(i & 3), 6);
         if ((i % 4) == 1) send(2'(i & 3), 2'(i >> 2), 2);
      end
      tick(10);
      chk(exp_q.size() == 0, "R7 all codes seen", exp_q.size(), 0);
      done = 1'b1;
      summary();
   end
endmodule